// File: doc/BRIEF.md
# Sixteen-Bit Timer with Free-Run and Clear-on-Match Modes

This block is a 16-bit up-counter that advances once per clock-enable pulse from an external prescaler. It runs in one of two ways. In free-run mode it counts up and rolls over from all ones to zero. In clear-on-match mode the count returns to zero on the tick where it equals a chosen top value. The top value comes either from the compare-A register or from the capture register, and the 4-bit mode code picks which one.

Three sticky flags report events: rollover, a top match against compare A, and a top match against the capture register. Software clears each flag by pulsing its write-one-to-clear strobe. A single waveform pin can toggle on every top match. This produces a square wave whose frequency depends on the top value.

Bus writes to the counter, compare A and capture register all take effect on the next clock edge. The top registers have no shadow copy, so a new top value applies at once.

Top module: `tmr16_ctc`

## Requirements
- R1: After reset, the counter, both top registers, all three flags and the waveform output are zero.
- R2: Mode codes other than 4 and 12 select free-run. In free-run, the counter rises by one at each edge where tick is high and no counter write is pending, and it holds while tick is low. The value after 0xFFFF is 0x0000.
- R3: The overflow flag goes high at the same edge where an increment takes the counter from 0xFFFF to 0x0000, in any mode. Hardware never clears it.
- R4: Mode code 4 selects clear-on-match with compare A. At a ticking edge where the counter equals compare A, the counter becomes zero and the compare-A flag is set. The capture flag is not affected.
- R5: Mode code 12 selects clear-on-match with the capture register. At a ticking edge where the counter equals the capture register, the counter becomes zero and the capture flag is set. The compare-A flag is not affected.
- R6: A write to compare A or to the capture register applies at the next edge. If the new top is below the count, the counter keeps rising to 0xFFFF and wraps, setting the overflow flag, before it can match.
- R7: A counter write loads the write data at the next edge whether or not tick is high. It overrides the increment and the clear, and that edge raises neither a match flag nor the overflow flag.
- R8: With compare-output code 1 (binary 01), the waveform output inverts at every top match in either clear-on-match mode. With codes 0, 2 and 3 it holds its level.
- R9: With compare-output code 1, mode 4 and compare A equal to zero, the waveform output inverts on every tick, giving a period of two ticks.
- R10: Each flag clears at the next edge after its clear strobe is pulsed. If a set and a clear fall on the same edge, the flag ends up set.
- R11: When the top equals 0xFFFF, a match at count 0xFFFF clears the counter and sets the match flag but does not set the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from prescaler |
| mode_sel | input | 4 | Mode code: 4 = clear on compare A, 12 = clear on capture, others free-run |
| com_sel | input | 2 | Compare-output code: 1 = toggle on match, others hold |
| wr_data | input | 16 | Shared write data |
| wr_cnt | input | 1 | Load counter from wr_data |
| wr_cmpa | input | 1 | Load compare A from wr_data |
| wr_cap | input | 1 | Load capture register from wr_data |
| clr_ovf | input | 1 | Write-one-to-clear overflow flag |
| clr_cmpa | input | 1 | Write-one-to-clear compare-A flag |
| clr_cap | input | 1 | Write-one-to-clear capture flag |
| count | output | 16 | Current counter value |
| ovf_flag | output | 1 | Overflow flag |
| cmpa_flag | output | 1 | Compare-A top-match flag |
| cap_flag | output | 1 | Capture top-match flag |
| wave_out | output | 1 | Waveform output |

## Verification
The properties assume that mode_sel and com_sel are held steady across any edge they reason about. The stimulus changes these two inputs only between runs, while tick is low, and it puts them in place one cycle before a run starts. The properties also assume that a counter write and a tick may coincide. The stimulus exercises that case on purpose, so the suppression rule is tested and not merely assumed. The top registers are loaded on cycles without a tick, except in the late-top case, where the point is that the count has already passed the new top.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    typedef enum logic [1:0] {
        MODE_FREE    = 2'd0,
        MODE_CTC_A   = 2'd1,
        MODE_CTC_CAP = 2'd2
    } mode_e;

    localparam logic [3:0] CODE_CTC_A   = 4'd4;
    localparam logic [3:0] CODE_CTC_CAP = 4'd12;
    localparam logic [1:0] COM_TOGGLE   = 2'd1;

    localparam int FLAG_OVF  = 0;
    localparam int FLAG_CMPA = 1;
    localparam int FLAG_CAP  = 2;
    localparam int NUM_FLAGS = 3;

    function automatic mode_e decode_mode(input logic [3:0] code);
        if (code == CODE_CTC_A)
            return MODE_CTC_A;
        else if (code == CODE_CTC_CAP)
            return MODE_CTC_CAP;
        else
            return MODE_FREE;
    endfunction
endpackage

// File: rtl/tmr16_topregs.sv
module tmr16_topregs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wr_data,
    input  logic         wr_a,
    input  logic         wr_c,
    output logic [W-1:0] top_a,
    output logic [W-1:0] top_c
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_a <= '0;
            top_c <= '0;
        end else begin
            if (wr_a) top_a <= wr_data;
            if (wr_c) top_c <= wr_data;
        end
    end
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter
    import tmr16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  mode_e        mode,
    input  logic [W-1:0] wr_data,
    input  logic         wr_cnt,
    input  logic [W-1:0] top_a,
    input  logic [W-1:0] top_c,
    output logic [W-1:0] cnt_q,
    output logic         hit_a,
    output logic         hit_c,
    output logic         wrap_evt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_d;
    logic [W-1:0] top_sel;
    logic         top_used;
    logic         adv;
    logic         hit;

    assign adv = tick && !wr_cnt;

    always_comb begin
        top_sel  = '0;
        top_used = 1'b0;
        unique case (mode)
            MODE_FREE: begin
                top_sel  = '0;
                top_used = 1'b0;
            end
            MODE_CTC_A: begin
                top_sel  = top_a;
                top_used = 1'b1;
            end
            MODE_CTC_CAP: begin
                top_sel  = top_c;
                top_used = 1'b1;
            end
        endcase
    end

    assign hit      = adv && top_used && (cnt_q == top_sel);
    assign hit_a    = hit && (mode == MODE_CTC_A);
    assign hit_c    = hit && (mode == MODE_CTC_CAP);
    assign wrap_evt = adv && !hit && (cnt_q == CNT_MAX);

    always_comb begin
        cnt_d = cnt_q;
        if (wr_cnt)
            cnt_d = wr_data;
        else if (hit)
            cnt_d = '0;
        else if (adv)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tmr16_flag.sv
module tmr16_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (set_i)  flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end
endmodule

// File: rtl/tmr16_wave.sv
module tmr16_wave
    import tmr16_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] com_sel,
    input  logic       match,
    output logic       wave_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            wave_q <= 1'b0;
        else if (match && com_sel == COM_TOGGLE)
            wave_q <= ~wave_q;
    end
endmodule

// File: rtl/tmr16_ctc.sv
module tmr16_ctc
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [3:0]       mode_sel,
    input  logic [1:0]       com_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             wr_cnt,
    input  logic             wr_cmpa,
    input  logic             wr_cap,
    input  logic             clr_ovf,
    input  logic             clr_cmpa,
    input  logic             clr_cap,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag,
    output logic             cmpa_flag,
    output logic             cap_flag,
    output logic             wave_out
);
    mode_e            mode;
    logic [CNT_W-1:0] top_a_q;
    logic [CNT_W-1:0] top_c_q;
    logic             hit_a;
    logic             hit_c;
    logic             wrap_evt;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_q;

    assign mode = decode_mode(mode_sel);

    tmr16_topregs #(.W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
        .wr_a(wr_cmpa), .wr_c(wr_cap),
        .top_a(top_a_q), .top_c(top_c_q)
    );

    tmr16_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
        .wr_data(wr_data), .wr_cnt(wr_cnt),
        .top_a(top_a_q), .top_c(top_c_q),
        .cnt_q(count), .hit_a(hit_a), .hit_c(hit_c), .wrap_evt(wrap_evt)
    );

    assign flag_set[FLAG_OVF]  = wrap_evt;
    assign flag_set[FLAG_CMPA] = hit_a;
    assign flag_set[FLAG_CAP]  = hit_c;
    assign flag_clr[FLAG_OVF]  = clr_ovf;
    assign flag_clr[FLAG_CMPA] = clr_cmpa;
    assign flag_clr[FLAG_CAP]  = clr_cap;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        tmr16_flag u_flag (
            .clk(clk), .rst_n(rst_n),
            .set_i(flag_set[i]), .clr_i(flag_clr[i]), .flag_q(flag_q[i])
        );
    end

    assign ovf_flag  = flag_q[FLAG_OVF];
    assign cmpa_flag = flag_q[FLAG_CMPA];
    assign cap_flag  = flag_q[FLAG_CAP];

    tmr16_wave u_wave (
        .clk(clk), .rst_n(rst_n), .com_sel(com_sel),
        .match(hit_a | hit_c), .wave_q(wave_out)
    );
endmodule

// File: rtl/tmr16_ctc_chk.sv
module tmr16_ctc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [3:0]       mode_sel,
    input logic [1:0]       com_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic             wr_cnt,
    input logic             clr_ovf,
    input logic [CNT_W-1:0] count,
    input logic             ovf_flag,
    input logic             cmpa_flag,
    input logic             cap_flag,
    input logic             wave_out,
    input logic [CNT_W-1:0] top_a_q,
    input logic [CNT_W-1:0] top_c_q
);
    localparam logic [CNT_W-1:0] ALL1 = '1;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(count));

    p_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && mode_sel == 4'd0) |=> count == $past(count) + 1'b1);

    p_wrap_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && mode_sel == 4'd0 && count == ALL1) |=> (ovf_flag && count == '0));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag);

    p_match_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && mode_sel == 4'd4 && count == top_a_q) |=> (count == '0 && cmpa_flag));

    p_match_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && mode_sel == 4'd12 && count == top_c_q) |=> (count == '0 && cap_flag));

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> count == $past(wr_data));

    p_wave_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (com_sel != 2'd1) |=> $stable(wave_out));
endmodule

bind tmr16_ctc tmr16_ctc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_sel(mode_sel),
    .com_sel(com_sel), .wr_data(wr_data), .wr_cnt(wr_cnt),
    .clr_ovf(clr_ovf), .count(count), .ovf_flag(ovf_flag),
    .cmpa_flag(cmpa_flag), .cap_flag(cap_flag), .wave_out(wave_out),
    .top_a_q(top_a_q), .top_c_q(top_c_q)
);

// File: tb/tmr16_ctc_test.sv
module tmr16_ctc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  mode_sel = 4'd0;
    logic [1:0]  com_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        wr_cnt = 1'b0, wr_cmpa = 1'b0, wr_cap = 1'b0;
    logic        clr_ovf = 1'b0, clr_cmpa = 1'b0, clr_cap = 1'b0;
    logic [15:0] count;
    logic        ovf_flag, cmpa_flag, cap_flag, wave_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr16_ctc uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_sel(mode_sel),
        .com_sel(com_sel), .wr_data(wr_data), .wr_cnt(wr_cnt),
        .wr_cmpa(wr_cmpa), .wr_cap(wr_cap), .clr_ovf(clr_ovf),
        .clr_cmpa(clr_cmpa), .clr_cap(clr_cap), .count(count),
        .ovf_flag(ovf_flag), .cmpa_flag(cmpa_flag), .cap_flag(cap_flag),
        .wave_out(wave_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock edge, then drop all strobes; sampling happens 1 ns after the edge
    task automatic pulse();
        @(posedge clk);
        #1;
        tick = 0; wr_cnt = 0; wr_cmpa = 0; wr_cap = 0;
        clr_ovf = 0; clr_cmpa = 0; clr_cap = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1; pulse();
        end
    endtask

    task automatic load_cnt(input logic [15:0] v);
        wr_data = v; wr_cnt = 1; pulse();
    endtask

    task automatic load_a(input logic [15:0] v);
        wr_data = v; wr_cmpa = 1; pulse();
    endtask

    task automatic load_c(input logic [15:0] v);
        wr_data = v; wr_cap = 1; pulse();
    endtask

    task automatic clear_all();
        clr_ovf = 1; clr_cmpa = 1; clr_cap = 1; pulse();
    endtask

    task automatic ctc_sweep(input logic [3:0] m, input int top);
        logic w0;
        mode_sel = m; com_sel = 2'd1;
        if (m == 4'd4) begin load_a(16'(top)); load_c(16'h8000); end
        else           begin load_c(16'(top)); load_a(16'h8000); end
        load_cnt(16'd0);
        clear_all();
        w0 = wave_out;
        for (int k = 1; k <= 3 * (top + 1) + 2; k++) begin
            tick = 1; pulse();
            chk(m == 4'd4 ? "R4 count" : "R5 count", 32'(count), 32'(k % (top + 1)));
            chk("R8 wave", 32'(wave_out), 32'(w0 ^ (((k / (top + 1)) % 2) == 1)));
            if (m == 4'd4) begin
                chk("R4 cmpa flag", 32'(cmpa_flag), 32'(k >= top + 1));
                chk("R4 cap flag untouched", 32'(cap_flag), 32'd0);
            end else begin
                chk("R5 cap flag", 32'(cap_flag), 32'(k >= top + 1));
                chk("R5 cmpa flag untouched", 32'(cmpa_flag), 32'd0);
            end
        end
        chk("R4 R5 no overflow", 32'(ovf_flag), 32'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic w_keep;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk("R1 count", 32'(count), 0);
        chk("R1 ovf", 32'(ovf_flag), 0);
        chk("R1 cmpa", 32'(cmpa_flag), 0);
        chk("R1 cap", 32'(cap_flag), 0);
        chk("R1 wave", 32'(wave_out), 0);

        // R2 free-run with gapped ticks
        load_cnt(16'h1234);
        for (int i = 1; i <= 20; i++) begin
            tick = (i % 3 != 0); pulse();
        end
        chk("R2 gapped count", 32'(count), 32'h1234 + 14);
        // R2 other mode code behaves as free-run
        mode_sel = 4'd5; load_a(16'd3); load_cnt(16'd0);
        ticks(10);
        chk("R2 code5 free", 32'(count), 10);
        mode_sel = 4'd0;

        // R3 wrap and overflow
        load_cnt(16'hFFFD);
        ticks(2);
        chk("R3 ovf before wrap", 32'(ovf_flag), 0);
        chk("R3 at max", 32'(count), 32'hFFFF);
        ticks(1);
        chk("R2 wrap to zero", 32'(count), 0);
        chk("R3 ovf set at wrap", 32'(ovf_flag), 1);
        ticks(5);
        chk("R3 ovf sticky", 32'(ovf_flag), 1);

        // R10 clear and collision
        clr_ovf = 1; pulse();
        chk("R10 ovf cleared", 32'(ovf_flag), 0);
        load_cnt(16'hFFFF);
        tick = 1; clr_ovf = 1; pulse();
        chk("R10 set wins", 32'(ovf_flag), 1);
        clr_ovf = 1; pulse();
        chk("R10 cleared after", 32'(ovf_flag), 0);

        // R7 counter write beats tick, no overflow
        load_cnt(16'hFFFF);
        wr_data = 16'd7; wr_cnt = 1; tick = 1; pulse();
        chk("R7 load over tick", 32'(count), 7);
        chk("R7 no ovf", 32'(ovf_flag), 0);

        // R4 R5 R8 R9 sweeps over small tops
        for (int t = 0; t <= 5; t++) ctc_sweep(4'd4, t);
        for (int t = 0; t <= 5; t++) ctc_sweep(4'd12, t);

        // R9 top zero toggles each tick
        mode_sel = 4'd4; com_sel = 2'd1; load_a(16'd0); load_cnt(16'd0);
        w_keep = wave_out;
        for (int k = 1; k <= 8; k++) begin
            ticks(1);
            chk("R9 toggle each tick", 32'(wave_out), 32'(w_keep ^ (k % 2 == 1)));
        end

        // R8 other output codes hold
        for (int c = 0; c < 4; c++) begin
            if (c == 1) continue;
            com_sel = 2'(c); pulse();
            w_keep = wave_out;
            ticks(6);
            chk("R8 hold", 32'(wave_out), 32'(w_keep));
        end

        // R7 write equal to top suppresses match
        com_sel = 2'd0; load_a(16'd5); clear_all();
        wr_data = 16'd5; wr_cnt = 1; tick = 1; pulse();
        chk("R7 count loaded", 32'(count), 5);
        chk("R7 match suppressed", 32'(cmpa_flag), 0);
        ticks(1);
        chk("R4 match after load", 32'(count), 0);
        chk("R4 flag after load", 32'(cmpa_flag), 1);

        // R6 late top forces full wrap
        load_a(16'd10); load_cnt(16'hFFF0); clear_all();
        ticks(16);
        chk("R6 wrapped", 32'(count), 0);
        chk("R6 ovf on wrap", 32'(ovf_flag), 1);
        chk("R6 no early match", 32'(cmpa_flag), 0);
        ticks(10);
        chk("R6 reached top", 32'(count), 10);
        ticks(1);
        chk("R6 cleared at top", 32'(count), 0);
        chk("R6 match flag", 32'(cmpa_flag), 1);
        // R6 capture top lowered mid-count
        mode_sel = 4'd12; load_c(16'd100); load_cnt(16'hFFF8); clear_all();
        ticks(3);
        load_c(16'd2);
        ticks(5);
        chk("R6 cap wrap", 32'(count), 0);
        chk("R6 cap ovf", 32'(ovf_flag), 1);
        ticks(3);
        chk("R6 cap match", 32'(count), 0);
        chk("R6 cap flag", 32'(cap_flag), 1);

        // R11 top at all ones
        mode_sel = 4'd4; load_a(16'hFFFF); load_cnt(16'hFFFE); clear_all();
        ticks(1);
        chk("R11 at max", 32'(count), 32'hFFFF);
        ticks(1);
        chk("R11 cleared", 32'(count), 0);
        chk("R11 match flag", 32'(cmpa_flag), 1);
        chk("R11 no ovf", 32'(ovf_flag), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule